// File: doc/BRIEF.md
# In-Flight Instruction Block Tracker

This block sequences a processor that executes programs as atomic blocks of up to 128 instructions. It keeps a pool of eight block frames. A frame is claimed when a block starts fetching. The frame then moves through its life as fetch and execution completion reports arrive. The frame is released when the whole block retires in one step. Several blocks are in flight at once, and every block except the oldest of its thread is speculative. For one thread this gives a window of up to 1024 instructions.

A mode input splits the pool into equal, contiguous slices:

- one thread with eight frames
- two threads with four frames each
- four threads with two frames each, so 256 instructions per thread

Within a slice, frames are used as a ring. Commit always takes the oldest frame of a thread. It is offered to the outside as a valid/acknowledge handshake. A mispeculation flush names a frame and releases that frame and every younger frame of the same thread in one cycle. A one-cycle pulse reports that the flush took effect.

Top module: `bt_tracker`

## Requirements
- R1: After reset no commit is offered (`commit_valid`=0), `flush_done`=0, and the first fetch of thread 0 is granted frame 0.
- R2: A fetch request is granted combinationally in the cycle it is presented, provided its thread is active and has a free frame. Successive grants of a thread hand out the frames of its slice in ascending ring order.
- R3: A fetch request of a thread whose slice is fully in flight is not granted. The slice sizes are 8, 4 and 2 frames in the one-, two- and four-thread modes.
- R4: A fetch-done report moves a fetching frame to executing. An exec-done report moves an executing frame to complete. A report aimed at a frame in any other state is ignored.
- R5: Only the oldest in-flight frame of a thread may commit, and only once it is complete. A younger complete frame waits.
- R6: The commit offer is asserted one cycle after its frame became complete (when the port is idle). It holds `commit_fid`/`commit_tid` steady until `commit_ack`. It drops in the cycle after the acknowledge, and the frame becomes free.
- R7: A flush aimed at an in-flight frame releases it and all younger frames of its thread in one cycle. `flush_done` pulses for one cycle after the request, and that thread's next grant reuses the flushed frame.
- R8: A flush aimed at a frame that is not in flight is ignored: no `flush_done` pulse, and the thread's allocation order is unchanged.
- R9: `thread_mode` encodes 0 as one thread, 1 as two threads and 2 or 3 as four threads. Thread t owns frames t*S to t*S+S-1, where S is the slice size. Fetches from a thread number at or above the active count are never granted.
- R10: Only one commit is offered at a time. When several threads have a complete oldest frame, the lowest thread number goes first.
- R11: A fetch request is not granted in a cycle in which a flush request names a frame of the same thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thread_mode | input | 2 | Pool split: 0 = one thread, 1 = two, 2/3 = four |
| fetch_req | input | 1 | Request a frame for a new block |
| fetch_tid | input | 2 | Thread of the fetch request |
| fetch_grant | output | 1 | Request accepted this cycle |
| fetch_fid | output | 3 | Frame assigned to the granted block |
| fetch_done | input | 1 | Block fetch finished |
| fetch_done_fid | input | 3 | Frame of the fetch-done report |
| exec_done | input | 1 | Block execution finished |
| exec_done_fid | input | 3 | Frame of the exec-done report |
| flush_req | input | 1 | Mispeculation flush request |
| flush_fid | input | 3 | Oldest frame to discard |
| flush_done | output | 1 | One-cycle pulse: flush took effect |
| commit_valid | output | 1 | A block is being committed |
| commit_fid | output | 3 | Frame being committed |
| commit_tid | output | 2 | Thread being committed |
| commit_ack | input | 1 | Downstream accepted the commit |

## Verification
The assertions assume that `thread_mode` changes only while reset is held. They also assume that no flush names the frame currently offered for commit, and that `commit_ack` is raised only while `commit_valid` is high. The directed bench sets the mode inside its reset task and acknowledges only an offered commit. Its flushes always target frames of a thread that has no pending commit.

// File: rtl/bt_pkg.sv
// Shared types for the block tracker.
// Assumes: nothing; holds only declarations.
package bt_pkg;
    localparam int MAX_THREADS = 4;

    typedef enum logic [2:0] {
        FR_FREE,
        FR_FETCH,
        FR_EXEC,
        FR_DONE,
        FR_COMMIT
    } frame_st_e;
endpackage

// File: rtl/bt_frame.sv
// One block frame: steps through its life cycle on tagged events.
// Assumes: kill is never raised while the frame is committing.
module bt_frame (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic              fetched,
    input  logic              executed,
    input  logic              commit_go,
    input  logic              commit_ack_i,
    input  logic              kill,
    output bt_pkg::frame_st_e st
);
    import bt_pkg::*;

    // Frame state register; a kill overrides every other event.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            st <= FR_FREE;
        end else begin
            case (st)
                FR_FREE:   if (alloc)        st <= FR_FETCH;
                FR_FETCH:  if (fetched)      st <= FR_EXEC;
                FR_EXEC:   if (executed)     st <= FR_DONE;
                FR_DONE:   if (commit_go)    st <= FR_COMMIT;
                FR_COMMIT: if (commit_ack_i) st <= FR_FREE;
                default:                     st <= FR_FREE;
            endcase
        end
    end
endmodule

// File: rtl/bt_thread_ctl.sv
// Per-thread ring bookkeeping: oldest offset and occupancy within the slice.
// Assumes: alloc only when not full, retire only when count is non-zero.
module bt_thread_ctl #(
    parameter int FID_W = 3,
    parameter int CNT_W = FID_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FID_W-1:0] mask,
    input  logic [CNT_W-1:0] size,
    input  logic             alloc,
    input  logic             retire,
    input  logic             flush,
    input  logic [FID_W-1:0] flush_off,
    output logic [FID_W-1:0] head,
    output logic [FID_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    logic [FID_W-1:0] rel;

    // Distance of the flushed frame from the oldest one.
    always_comb rel = (flush_off - head) & mask;

    // Oldest pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            count <= '0;
        end else begin
            if (retire) head <= (head + 1'b1) & mask;
            if (flush)  count <= CNT_W'(rel) - CNT_W'(retire);
            else        count <= count + CNT_W'(alloc) - CNT_W'(retire);
        end
    end

    // Next free slot and fullness.
    always_comb begin
        tail = (head + count[FID_W-1:0]) & mask;
        full = (count == size);
    end
endmodule

// File: rtl/bt_commit_arb.sv
// Fixed-priority pick among threads whose oldest frame can commit.
// Assumes: ready already excludes a busy commit port.
module bt_commit_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  ready,
    output logic          any,
    output logic [IW-1:0] pick
);
    // Lowest index wins.
    always_comb begin
        any  = |ready;
        pick = '0;
        for (int t = N - 1; t >= 0; t--) begin
            if (ready[t]) pick = IW'(t);
        end
    end
endmodule

// File: rtl/bt_tracker.sv
// Top: frame pool, per-thread rings, in-order commit and flush.
// Assumes: thread_mode changes only in reset; no flush names the frame
// being committed; commit_ack only while commit_valid.
module bt_tracker #(
    parameter int NUM_FRAMES = 8,
    parameter int FID_W      = $clog2(NUM_FRAMES),
    parameter int TID_W      = $clog2(bt_pkg::MAX_THREADS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       thread_mode,
    input  logic             fetch_req,
    input  logic [TID_W-1:0] fetch_tid,
    output logic             fetch_grant,
    output logic [FID_W-1:0] fetch_fid,
    input  logic             fetch_done,
    input  logic [FID_W-1:0] fetch_done_fid,
    input  logic             exec_done,
    input  logic [FID_W-1:0] exec_done_fid,
    input  logic             flush_req,
    input  logic [FID_W-1:0] flush_fid,
    output logic             flush_done,
    output logic             commit_valid,
    output logic [FID_W-1:0] commit_fid,
    output logic [TID_W-1:0] commit_tid,
    input  logic             commit_ack
);
    import bt_pkg::*;
    localparam int NTH   = MAX_THREADS;
    localparam int CNT_W = FID_W + 1;

    int unsigned       lg;
    logic [FID_W-1:0]  mask;
    logic [CNT_W-1:0]  size;
    logic [NTH-1:0]    active;
    frame_st_e         fst [NUM_FRAMES];
    logic [FID_W-1:0]  head [NTH];
    logic [FID_W-1:0]  tail [NTH];
    logic [CNT_W-1:0]  cnt  [NTH];
    logic [NTH-1:0]    full;
    logic [FID_W-1:0]  cand_fid [NTH];
    logic [NTH-1:0]    ready;
    logic              arb_any;
    logic [TID_W-1:0]  arb_pick;
    logic              commit_busy;
    logic [TID_W-1:0]  flush_tid;
    logic [FID_W-1:0]  fl_rel;
    logic              flush_ok;
    logic [NUM_FRAMES-1:0] kill;
    logic [NUM_FRAMES-1:0] committing_vec;
    logic              ack_fire;

    // Slice geometry from the thread mode.
    always_comb begin
        case (thread_mode)
            2'd0:    lg = FID_W;
            2'd1:    lg = FID_W - 1;
            default: lg = FID_W - 2;
        endcase
        mask = FID_W'((1 << lg) - 1);
        size = CNT_W'(1 << lg);
        for (int t = 0; t < NTH; t++) active[t] = (t < (1 << (FID_W - lg)));
    end

    // Fetch grant: thread active, not full, not being flushed.
    always_comb begin
        flush_tid   = TID_W'(flush_fid >> lg);
        fetch_fid   = (FID_W'(fetch_tid) << lg) | tail[fetch_tid];
        fetch_grant = fetch_req && active[fetch_tid] && !full[fetch_tid]
                      && !(flush_req && flush_tid == fetch_tid);
    end

    // Flush validity and the set of frames it releases.
    always_comb begin
        fl_rel   = (flush_fid - head[flush_tid]) & mask;
        flush_ok = flush_req && ({1'b0, fl_rel} < cnt[flush_tid]);
        for (int i = 0; i < NUM_FRAMES; i++) begin
            logic [FID_W-1:0] rel_i;
            rel_i   = (FID_W'(i) - head[flush_tid]) & mask;
            kill[i] = flush_ok && (TID_W'(i >> lg) == flush_tid)
                      && (rel_i >= fl_rel) && ({1'b0, rel_i} < cnt[flush_tid]);
        end
    end

    assign ack_fire = commit_busy && commit_ack;

    generate
        for (genvar t = 0; t < NTH; t++) begin : g_thr
            bt_thread_ctl #(.FID_W(FID_W), .CNT_W(CNT_W)) u_thr (
                .clk       (clk),
                .rst_n     (rst_n),
                .mask      (mask),
                .size      (size),
                .alloc     (fetch_grant && fetch_tid == TID_W'(t)),
                .retire    (ack_fire && commit_tid == TID_W'(t)),
                .flush     (flush_ok && flush_tid == TID_W'(t)),
                .flush_off (flush_fid & mask),
                .head      (head[t]),
                .tail      (tail[t]),
                .count     (cnt[t]),
                .full      (full[t])
            );
            // Oldest frame of this thread and its commit readiness.
            always_comb begin
                cand_fid[t] = FID_W'(t << lg) | head[t];
                ready[t]    = active[t] && (cnt[t] != '0)
                              && (fst[cand_fid[t]] == FR_DONE) && !commit_busy;
            end
        end

        for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frm
            bt_frame u_frm (
                .clk          (clk),
                .rst_n        (rst_n),
                .alloc        (fetch_grant && fetch_fid == FID_W'(i)),
                .fetched      (fetch_done && fetch_done_fid == FID_W'(i)),
                .executed     (exec_done && exec_done_fid == FID_W'(i)),
                .commit_go    (arb_any && cand_fid[arb_pick] == FID_W'(i)),
                .commit_ack_i (ack_fire && commit_fid == FID_W'(i)),
                .kill         (kill[i]),
                .st           (fst[i])
            );
            assign committing_vec[i] = (fst[i] == FR_COMMIT);
        end
    endgenerate

    bt_commit_arb #(.N(NTH), .IW(TID_W)) u_arb (
        .ready (ready),
        .any   (arb_any),
        .pick  (arb_pick)
    );

    // Commit handshake and flush report registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_busy <= 1'b0;
            commit_fid  <= '0;
            commit_tid  <= '0;
            flush_done  <= 1'b0;
        end else begin
            flush_done <= flush_ok;
            if (arb_any) begin
                commit_busy <= 1'b1;
                commit_fid  <= cand_fid[arb_pick];
                commit_tid  <= arb_pick;
            end else if (ack_fire) begin
                commit_busy <= 1'b0;
            end
        end
    end

    assign commit_valid = commit_busy;
endmodule

// File: rtl/bt_tracker_chk.sv
// Property checker for bt_tracker, bound to every instance.
// Assumes: the input rules listed in the top module header.
module bt_tracker_chk #(
    parameter int NUM_FRAMES = 8,
    parameter int FID_W      = 3,
    parameter int TID_W      = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            thread_mode,
    input logic                  fetch_req,
    input logic [TID_W-1:0]      fetch_tid,
    input logic                  fetch_grant,
    input logic                  flush_req,
    input logic                  flush_done,
    input logic                  commit_valid,
    input logic [FID_W-1:0]      commit_fid,
    input logic                  commit_ack,
    input logic [NUM_FRAMES-1:0] committing_vec
);
    p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_grant |-> fetch_req);

    p_single_mode_tid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_grant && thread_mode == 2'd0) |-> (fetch_tid == '0));

    p_commit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !commit_ack) |=> (commit_valid && $stable(commit_fid)));

    p_commit_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && commit_ack) |=> !commit_valid);

    p_one_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(committing_vec));

    p_offer_has_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> ($countones(committing_vec) == 1));

    p_flush_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> $past(flush_req));
endmodule

bind bt_tracker bt_tracker_chk #(
    .NUM_FRAMES (NUM_FRAMES),
    .FID_W      (FID_W),
    .TID_W      (TID_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .thread_mode    (thread_mode),
    .fetch_req      (fetch_req),
    .fetch_tid      (fetch_tid),
    .fetch_grant    (fetch_grant),
    .flush_req      (flush_req),
    .flush_done     (flush_done),
    .commit_valid   (commit_valid),
    .commit_fid     (commit_fid),
    .commit_ack     (commit_ack),
    .committing_vec (committing_vec)
);

// File: tb/tb_bt_tracker.sv
// Directed bench for bt_tracker; one task per scenario.
module tb_bt_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] thread_mode = 2'd0;
    logic       fetch_req = 1'b0;
    logic [1:0] fetch_tid = '0;
    logic       fetch_grant;
    logic [2:0] fetch_fid;
    logic       fetch_done = 1'b0;
    logic [2:0] fetch_done_fid = '0;
    logic       exec_done = 1'b0;
    logic [2:0] exec_done_fid = '0;
    logic       flush_req = 1'b0;
    logic [2:0] flush_fid = '0;
    logic       flush_done;
    logic       commit_valid;
    logic [2:0] commit_fid;
    logic [1:0] commit_tid;
    logic       commit_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    bt_tracker dut (
        .clk(clk), .rst_n(rst_n), .thread_mode(thread_mode),
        .fetch_req(fetch_req), .fetch_tid(fetch_tid),
        .fetch_grant(fetch_grant), .fetch_fid(fetch_fid),
        .fetch_done(fetch_done), .fetch_done_fid(fetch_done_fid),
        .exec_done(exec_done), .exec_done_fid(exec_done_fid),
        .flush_req(flush_req), .flush_fid(flush_fid), .flush_done(flush_done),
        .commit_valid(commit_valid), .commit_fid(commit_fid),
        .commit_tid(commit_tid), .commit_ack(commit_ack)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] mode);
        rst_n = 1'b0;
        thread_mode = mode;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic fetch(input logic [1:0] tid, output logic g, output logic [2:0] f);
        fetch_req = 1'b1;
        fetch_tid = tid;
        #1;
        g = fetch_grant;
        f = fetch_fid;
        tick();
        fetch_req = 1'b0;
    endtask

    task automatic expect_fetch(input string req, input logic [1:0] tid, input int fid);
        logic g;
        logic [2:0] f;
        fetch(tid, g, f);
        chk(req, int'(g), 1);
        chk(req, int'(f), fid);
    endtask

    task automatic expect_stall(input string req, input logic [1:0] tid);
        logic g;
        logic [2:0] f;
        fetch(tid, g, f);
        chk(req, int'(g), 0);
    endtask

    task automatic fdone(input logic [2:0] fid);
        fetch_done = 1'b1; fetch_done_fid = fid; tick(); fetch_done = 1'b0;
    endtask

    task automatic edone(input logic [2:0] fid);
        exec_done = 1'b1; exec_done_fid = fid; tick(); exec_done = 1'b0;
    endtask

    task automatic ack();
        commit_ack = 1'b1; tick(); commit_ack = 1'b0;
    endtask

    task automatic flush(input logic [2:0] fid);
        flush_req = 1'b1; flush_fid = fid; tick(); flush_req = 1'b0;
    endtask

    // R1: reset state.
    task automatic t_reset();
        do_reset(2'd0);
        chk("R1 commit_valid", int'(commit_valid), 0);
        chk("R1 flush_done", int'(flush_done), 0);
        expect_fetch("R1 first grant", 2'd0, 0);
    endtask

    // R2/R3: single thread fills all eight frames, then stalls.
    task automatic t_fill_single();
        do_reset(2'd0);
        for (int k = 0; k < 8; k++) expect_fetch("R2 ring order", 2'd0, k);
        expect_stall("R3 full stall", 2'd0);
    endtask

    // R4/R5/R6: in-order commit, ignored reports, handshake.
    task automatic t_order();
        do_reset(2'd0);
        expect_fetch("R2 alloc", 2'd0, 0);
        expect_fetch("R2 alloc", 2'd0, 1);
        fdone(3'd1);
        edone(3'd1);
        tick(); tick();
        chk("R5 younger waits", int'(commit_valid), 0);
        edone(3'd0);
        fdone(3'd0);
        tick(); tick();
        chk("R4 exec_done while fetching ignored", int'(commit_valid), 0);
        edone(3'd0);
        chk("R6 offer not before next edge", int'(commit_valid), 0);
        tick();
        chk("R6 offer valid", int'(commit_valid), 1);
        chk("R5 oldest first", int'(commit_fid), 0);
        tick(); tick();
        chk("R6 held", int'(commit_valid), 1);
        chk("R6 fid stable", int'(commit_fid), 0);
        ack();
        chk("R6 drop after ack", int'(commit_valid), 0);
        tick();
        chk("R5 next commit", int'(commit_valid), 1);
        chk("R5 next fid", int'(commit_fid), 1);
        ack();
        expect_fetch("R6 frames freed, ring continues", 2'd0, 2);
    endtask

    // R7/R8: flush of younger frames, and flush of a free frame.
    task automatic t_flush();
        do_reset(2'd0);
        for (int k = 0; k < 4; k++) expect_fetch("R2 alloc", 2'd0, k);
        flush(3'd2);
        chk("R7 flush_done pulse", int'(flush_done), 1);
        tick();
        chk("R7 pulse one cycle", int'(flush_done), 0);
        expect_fetch("R7 reuse flushed frame", 2'd0, 2);
        flush(3'd6);
        chk("R8 no pulse", int'(flush_done), 0);
        expect_fetch("R8 order unchanged", 2'd0, 3);
    endtask

    // R9/R3: two- and four-thread slicing.
    task automatic t_modes();
        do_reset(2'd1);
        expect_fetch("R9 tid1 base", 2'd1, 4);
        expect_fetch("R9 tid0 base", 2'd0, 0);
        for (int k = 5; k < 8; k++) expect_fetch("R2 slice order", 2'd1, k);
        expect_stall("R3 slice of four full", 2'd1);
        expect_stall("R9 inactive tid2", 2'd2);
        do_reset(2'd3);
        expect_fetch("R9 mode3 tid3 base", 2'd3, 6);
        expect_fetch("R9 mode3 tid3 second", 2'd3, 7);
        expect_stall("R3 slice of two full", 2'd3);
    endtask

    // R10: one commit at a time, lowest thread first.
    task automatic t_arb();
        do_reset(2'd2);
        expect_fetch("R9 tid1", 2'd1, 2);
        expect_fetch("R9 tid2", 2'd2, 4);
        expect_fetch("R9 tid3", 2'd3, 6);
        fdone(3'd2);
        edone(3'd2);
        tick();
        chk("R6 offer", int'(commit_valid), 1);
        chk("R10 tid1 fid", int'(commit_fid), 2);
        fdone(3'd6); edone(3'd6); fdone(3'd4); edone(3'd4);
        chk("R10 single offer held", int'(commit_fid), 2);
        chk("R10 single offer tid", int'(commit_tid), 1);
        ack();
        tick();
        chk("R10 lowest thread next", int'(commit_tid), 2);
        chk("R10 lowest thread fid", int'(commit_fid), 4);
        ack();
        tick();
        chk("R10 last thread", int'(commit_tid), 3);
        chk("R10 last fid", int'(commit_fid), 6);
        ack();
    endtask

    // R11: flush beats fetch within one thread.
    task automatic t_flush_prio();
        logic g;
        do_reset(2'd2);
        expect_fetch("R11 setup", 2'd0, 0);
        fetch_req = 1'b1; fetch_tid = 2'd0;
        flush_req = 1'b1; flush_fid = 3'd0;
        #1;
        g = fetch_grant;
        chk("R11 no grant during own flush", int'(g), 0);
        tick();
        fetch_req = 1'b0; flush_req = 1'b0;
        chk("R7 flush_done", int'(flush_done), 1);
        expect_fetch("R7 reuse frame 0", 2'd0, 0);
    endtask

    initial begin
        t_reset();
        t_fill_single();
        t_order();
        t_flush();
        t_modes();
        t_arb();
        t_flush_prio();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule